// File: doc/BRIEF.md
# Zero-Wait Flow-Through Burst SRAM

This block is a synchronous single-port memory with byte-lane write control. It is built so that the data bus never has to idle when traffic changes from reads to writes or back. A read is flow-through. Once the edge has registered the address, the stored word drives the output for the rest of that cycle. A write takes its data one enabled edge after the edge that registered its address. That way the write data occupies the same bus slot a read's result would have used, and any command can follow any other with no gap.

A command is loaded when the advance strobe is sampled low. The chip-enable triple then decides whether the cycle is a deselect. If the chip is selected, the write-enable decides between a read and a write. When the strobe is sampled high, a 2-bit burst counter steps and the loaded operation continues. The low two address bits follow either an XOR (interleaved) order or a wrap-around increment (linear) order, chosen by the order-select strap. An active-low clock enable freezes the whole block, including a write that is waiting for its data.

Top module: `nobl_sram`

## Requirements
- R1: After reset the data-output enable is low and no write is pending.
- R2: On an edge where cke_n is high, every input is ignored and all state is held: the loaded operation, the address, the burst count and any write waiting for data. A waiting write takes its data at the next edge with cke_n low.
- R3: An edge with cke_n low and adv low loads addr as the base address and clears the burst count. For a read, dout_oe is high and dout shows the word at that address after the same edge.
- R4: An edge with cke_n low and adv high, while a read or write is loaded, adds one modulo 4 to the burst count and continues the same operation. The count wraps from 3 to 0.
- R5: With mode high, the low two bits of the accessed address are the base's low bits XOR the count, and the upper bits equal the base's upper bits.
- R6: With mode low, the low two bits of the accessed address are (base low bits + count) modulo 4, and the upper bits are unchanged.
- R7: A write loaded or continued at edge N stores din, sampled at the next edge with cke_n low, into the address accessed at edge N.
- R8: Byte-lane enable bw_n[i] (active low), sampled at edge N together with the write's address, controls whether bits [8i+7:8i] change. Lanes with bw_n[i] high keep their old value.
- R9: A load with ce1_n high, ce2 low or ce3_n high is a deselect. It writes nothing and leaves dout_oe low. Advance edges during a deselect keep it deselected.
- R10: Reads and writes follow each other with no idle cycle. dout_oe is low during every write-data cycle. A read loaded on the edge that commits a write sees the new data.
- R11: we_n is ignored on advance edges. The operation type comes only from the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| adv | input | 1 | Low: load new command; high: advance burst |
| we_n | input | 1 | Active-low write select, sampled on loads |
| bw_n | input | NB | Active-low byte-lane write enables |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| din | input | NB*8 | Write data (inbound half of the shared bus) |
| dout | output | NB*8 | Read data (outbound half); zero when not driving |
| dout_oe | output | 1 | High when the block drives the bus |

## Verification
The read result for a command registered at an enabled edge is due during the cycle right after that edge. The bench samples it a quarter period after the rising edge. A write's effect shows only after the following enabled edge, so it is checked by a later read. The driver computes each cycle's expected bus state from a reference model while it applies the inputs before the edge. It queues one item per edge, and the monitor pops exactly one item a quarter period after each edge. Stalled edges also push an item, which carries the held expectation, so the queue stays aligned with the design's cycles.

// File: rtl/nobl_sram_pkg.sv
package nobl_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits for a burst beat; interleave selects XOR order.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] count,
                                             input logic       interleave);
        return interleave ? (start ^ count) : (start + count);
    endfunction

endpackage

// File: rtl/nobl_burst_addr.sv
module nobl_burst_addr
    import nobl_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    count,
    input  logic          interleave,
    output logic [AW-1:0] word_addr
);
    always_comb begin
        word_addr = {base[AW-1:2], burst_low(base[1:0], count, interleave)};
    end
endmodule

// File: rtl/nobl_array.sv
module nobl_array #(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [NB-1:0]     wr_lane,
    input  logic [NB*8-1:0]   wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [NB*8-1:0]   rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [NB-1:0][7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < NB; l++) begin
                if (wr_lane[l]) store[wr_addr][l] <= wr_data[l*8 +: 8];
            end
        end
    end

    always_comb begin
        rd_data = store[rd_addr];
    end
endmodule

// File: rtl/nobl_ctrl.sv
module nobl_ctrl
    import nobl_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          adv,
    input  logic          we_n,
    input  logic [NB-1:0] bw_n,
    input  logic          selected,
    input  logic          mode,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] base_q,
    output logic [1:0]    cnt_q,
    output logic          wr_pend_q,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [NB-1:0] wr_lane
);
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
        logic          wpend;
        logic [AW-1:0] waddr;
        logic [NB-1:0] wlane;
    } state_t;

    state_t s_d, s_q;
    logic [AW-1:0] beat_addr_d;

    always_comb begin
        s_d         = s_q;
        beat_addr_d = '0;
        if (!cke_n) begin
            if (!adv) begin
                s_d.base = addr;
                s_d.cnt  = 2'd0;
                if (!selected)  s_d.op = OP_IDLE;
                else if (we_n)  s_d.op = OP_READ;
                else            s_d.op = OP_WRITE;
            end else if (s_q.op != OP_IDLE) begin
                s_d.cnt = s_q.cnt + 2'd1;
            end
            beat_addr_d = {s_d.base[AW-1:2], burst_low(s_d.base[1:0], s_d.cnt, mode)};
            s_d.wpend   = (s_d.op == OP_WRITE);
            s_d.waddr   = beat_addr_d;
            s_d.wlane   = ~bw_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{op: OP_IDLE, base: '0, cnt: 2'd0, wpend: 1'b0, waddr: '0, wlane: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign op_q      = s_q.op;
    assign base_q    = s_q.base;
    assign cnt_q     = s_q.cnt;
    assign wr_pend_q = s_q.wpend;
    assign wr_en     = !cke_n && s_q.wpend;
    assign wr_addr   = s_q.waddr;
    assign wr_lane   = s_q.wlane;

    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(s_q));

    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv) |=> (cnt_q == 2'd0 && base_q == $past(addr)));

    assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && op_q != OP_IDLE) |=> (cnt_q == $past(cnt_q) + 2'd1 && $stable(op_q)));

    assert_we_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv) |=> $stable(op_q));
endmodule

// File: rtl/nobl_sram.sv
module nobl_sram
    import nobl_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             adv,
    input  logic             we_n,
    input  logic [NB-1:0]    bw_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             mode,
    input  logic [AW-1:0]    addr,
    input  logic [NB*8-1:0]  din,
    output logic [NB*8-1:0]  dout,
    output logic             dout_oe
);
    localparam int DW = NB * 8;

    op_e           op_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          wr_pend_q;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [NB-1:0] wr_lane;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          selected;

    assign selected = !ce1_n && ce2 && !ce3_n;

    nobl_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .selected(selected), .mode(mode), .addr(addr),
        .op_q(op_q), .base_q(base_q), .cnt_q(cnt_q), .wr_pend_q(wr_pend_q),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane)
    );

    nobl_burst_addr #(.AW(AW)) u_rd_addr (
        .base(base_q), .count(cnt_q), .interleave(mode), .word_addr(rd_addr)
    );

    nobl_array #(.AW(AW), .NB(NB)) u_array (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane),
        .wr_data(din), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign dout_oe = (op_q == OP_READ);
    assign dout    = dout_oe ? rd_data : '0;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!dout_oe && !wr_pend_q));

    assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && !selected) |=> (!dout_oe && !wr_pend_q));

    assert_bus_free_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend_q |-> !dout_oe);

    assert_write_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && selected && !we_n) |=> wr_pend_q);
endmodule

// File: tb/nobl_sram_test.sv
module nobl_sram_test;
    localparam int CLK_P = 10;
    localparam logic [2:0] SEL = 3'b010; // {ce1_n, ce2, ce3_n}

    typedef struct {
        logic        oe;
        logic [31:0] data;
        string       tag;
    } sb_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0, adv = 1'b0, we_n = 1'b1, mode = 1'b0;
    logic [3:0]  bw_n = 4'hF;
    logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dout_oe;

    int checks = 0;
    int errors = 0;
    sb_t sbq[$];

    // reference model
    bit [31:0] ref_mem [64];
    int        m_op = 0;   // 0 idle, 1 read, 2 write
    bit [5:0]  m_base = '0;
    bit [1:0]  m_cnt = '0;
    bit        m_wp = 1'b0;
    bit [5:0]  m_wa = '0;
    bit [3:0]  m_wbe = '0;

    always #(CLK_P/2) clk = ~clk;

    nobl_sram #(.AW(6), .NB(4)) uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .mode(mode),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic cyc(input logic c_n, input logic a, input logic w_n,
                       input logic [3:0] b_n, input logic [2:0] ce,
                       input logic [5:0] ad, input logic [31:0] d,
                       input logic md, input string tag);
        bit [5:0] eff;
        sb_t item;
        @(negedge clk);
        cke_n = c_n; adv = a; we_n = w_n; bw_n = b_n;
        {ce1_n, ce2, ce3_n} = ce; addr = ad; din = d; mode = md;
        if (!c_n) begin
            if (m_wp) begin
                for (int l = 0; l < 4; l++)
                    if (m_wbe[l]) ref_mem[m_wa][l*8 +: 8] = d[l*8 +: 8];
            end
            if (!a) begin
                m_base = ad; m_cnt = 2'd0;
                m_op = (ce != SEL) ? 0 : (w_n ? 1 : 2);
            end else if (m_op != 0) begin
                m_cnt = m_cnt + 2'd1;
            end
            eff = {m_base[5:2], md ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            m_wp = (m_op == 2); m_wa = eff; m_wbe = ~b_n;
        end
        eff = {m_base[5:2], md ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
        item.oe = (m_op == 1);
        item.data = ref_mem[eff];
        item.tag = tag;
        sbq.push_back(item);
    endtask

    // monitor: one item per rising edge, sampled a quarter period later
    initial begin
        sb_t e;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                checks++;
                if (dout_oe !== e.oe || (e.oe && dout !== e.data)) begin
                    errors++;
                    $display("FAIL %s: oe=%0b dout=%h expected oe=%0b dout=%h",
                             e.tag, dout_oe, dout, e.oe, e.data);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++; // R1 reset state
        if (dout_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: oe=%0b expected oe=0", dout_oe);
        end

        // linear write burst at base 5: addresses 5,6,7,4 (R7, R6, R11)
        cyc(0, 0, 0, 4'h0, SEL, 6'd5, 32'h0,        0, "R7");
        cyc(0, 1, 1, 4'h0, SEL, 6'd0, 32'h1111_1111, 0, "R11");
        cyc(0, 1, 0, 4'h0, SEL, 6'd0, 32'h2222_2222, 0, "R6");
        cyc(0, 1, 1, 4'h0, SEL, 6'd0, 32'h3333_3333, 0, "R6");
        // last write data and a read load in the same cycle (R10)
        cyc(0, 0, 1, 4'hF, SEL, 6'd5, 32'h4444_4444, 0, "R10");
        cyc(0, 1, 0, 4'h0, SEL, 6'd0, 32'h0,        0, "R4");
        cyc(0, 1, 1, 4'hF, SEL, 6'd0, 32'h0,        0, "R6");
        cyc(0, 1, 1, 4'hF, SEL, 6'd0, 32'h0,        0, "R6");
        cyc(0, 1, 1, 4'hF, SEL, 6'd0, 32'h0,        0, "R4");
        // interleaved read from base 6: 6,7,4,5 (R5)
        cyc(0, 0, 1, 4'hF, SEL, 6'd6, 32'h0, 1, "R5");
        cyc(0, 1, 1, 4'hF, SEL, 6'd0, 32'h0, 1, "R5");
        cyc(0, 1, 1, 4'hF, SEL, 6'd0, 32'h0, 1, "R5");
        cyc(0, 1, 1, 4'hF, SEL, 6'd0, 32'h0, 1, "R5");
        // byte-lane write: lanes 0 and 2 only, then read back (R8)
        cyc(0, 0, 0, 4'b1010, SEL, 6'd5, 32'h0,         0, "R8");
        cyc(0, 0, 1, 4'hF,    SEL, 6'd5, 32'hFFFF_FFFF, 0, "R8");
        // deselects through each chip enable (R9)
        cyc(0, 0, 0, 4'h0, 3'b110, 6'd6, 32'h0,         0, "R9");
        cyc(0, 1, 0, 4'h0, SEL,    6'd0, 32'hDEAD_BEEF, 0, "R9");
        cyc(0, 0, 0, 4'h0, 3'b000, 6'd6, 32'hDEAD_BEEF, 0, "R9");
        cyc(0, 1, 0, 4'h0, SEL,    6'd0, 32'hDEAD_BEEF, 0, "R9");
        cyc(0, 0, 0, 4'h0, 3'b011, 6'd6, 32'hDEAD_BEEF, 0, "R9");
        cyc(0, 1, 0, 4'h0, SEL,    6'd0, 32'hDEAD_BEEF, 0, "R9");
        cyc(0, 0, 1, 4'hF, SEL,    6'd6, 32'hDEAD_BEEF, 0, "R9");
        // read with stall in the middle of a burst (R3, R2)
        cyc(0, 0, 1, 4'hF, SEL, 6'd4, 32'h0, 0, "R3");
        cyc(1, 0, 0, 4'h0, 3'b000, 6'd9, 32'hBAD0_BAD0, 0, "R2");
        cyc(1, 0, 0, 4'h0, 3'b000, 6'd9, 32'hBAD0_BAD0, 0, "R2");
        cyc(1, 1, 0, 4'h0, 3'b000, 6'd9, 32'hBAD0_BAD0, 0, "R2");
        cyc(0, 1, 1, 4'hF, SEL, 6'd0, 32'h0, 0, "R2");
        // write waiting for data across a stall (R2)
        cyc(0, 0, 0, 4'h0, SEL, 6'd7, 32'h0,         0, "R2");
        cyc(1, 0, 1, 4'hF, SEL, 6'd4, 32'hBAD1_BAD1, 0, "R2");
        cyc(1, 0, 1, 4'hF, SEL, 6'd4, 32'hBAD1_BAD1, 0, "R2");
        cyc(0, 0, 1, 4'hF, SEL, 6'd7, 32'hCAFE_F00D, 0, "R2");
        cyc(0, 0, 1, 4'hF, 3'b110, 6'd0, 32'h0, 0, "R9");
        cyc(0, 1, 1, 4'hF, SEL,    6'd0, 32'h0, 0, "R9");

        wait (sbq.size() == 0);
        @(posedge clk);
        #(CLK_P);
        summary();
        $finish;
    end
endmodule